// File: doc/BRIEF.md
# Switch Port Mirroring Selector

This block makes the mirroring decision for each frame inside the analyzer of a small multi-port Ethernet switch. Each frame decision arrives as a single-cycle strobe. The strobe carries four things: the ingress port number, the forwarding destination mask already computed upstream, a per-flow mirror flag from the classifier action, and a bypass flag. One cycle later the block returns the unchanged forwarding mask together with a mirror-copy port mask. Downstream replication logic uses the mirror-copy mask to send extra copies of the frame.

Three configuration words are held locally and written over a plain address/data/write-enable bus:

- a per-port ingress-mirror enable;
- an egress-mirror port mask;
- one mirror-destination port mask.

All three trigger kinds (ingress, egress and per-flow) copy the frame to that one destination mask. A frame from one mirrored source therefore reaches every configured mirror port. Frames injected by the CPU with the bypass flag set never produce a mirror copy.

Top module: `mirror_select`

## Requirements
- R1: A frame whose ingress port has its bit set in the ingress-enable word (address 0, bit n = port n) is mirrored.
- R2: A frame whose forwarding mask shares at least one port with the egress-mirror word (address 1, bit n = port n) is mirrored.
- R3: A frame whose per-flow mirror flag is 1 is mirrored.
- R4: A mirrored frame's copy mask is the destination word (address 2, bit n = port n) with the ingress port's bit cleared, the same for every trigger and not changed when several triggers fire together.
- R5: A frame with the bypass flag at 1 has a copy mask of zero whatever its triggers.
- R6: The copy mask never contains the frame's own ingress port.
- R7: A frame with no trigger active has a copy mask of zero.
- R8: The forwarding mask output equals the forwarding mask of the frame presented one cycle earlier.
- R9: The output valid is 1 exactly in the cycle after an input strobe; with valid at 0 both output masks are zero.
- R10: A configuration write takes effect from the next frame decision. A frame presented in the same cycle as a write uses the old values. A write to address 3 changes nothing.
- R11: After reset the output valid and both output masks are zero and all three configuration words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 2 | Configuration word select (0 ingress enable, 1 egress mask, 2 destination mask) |
| cfg_wr_data | input | NUM_PORTS | Configuration write data, one bit per port |
| frm_valid | input | 1 | Frame decision strobe |
| frm_src_port | input | PORT_W | Ingress port number of the frame |
| frm_fwd_mask | input | NUM_PORTS | Forwarding destination mask from upstream |
| frm_flow_mirror | input | 1 | Per-flow mirror flag from classifier action |
| frm_bypass | input | 1 | CPU-injected frame that skips the analyzer |
| out_valid | output | 1 | Decision valid, one cycle after frm_valid |
| out_fwd_mask | output | NUM_PORTS | Forwarding mask, passed through |
| out_mirror_mask | output | NUM_PORTS | Ports that receive a mirror copy |

## Verification
Every frame result is due on the first rising edge after the strobe, because the output stage is the only register on the path. The bench drives each frame on a falling edge and reads the outputs just after the following rising edge. A configuration write latches on one rising edge and can change only decisions made on later edges. For that reason the bench keeps its own copy of the configuration and updates it only after computing the expected result for a frame that shares the write's cycle.

// File: rtl/mirror_pkg.sv
package mirror_pkg;
  localparam int CFG_ADDR_W = 2;

  typedef enum logic [CFG_ADDR_W-1:0] {
    CFG_ING_EN   = 2'd0,
    CFG_EGR_MASK = 2'd1,
    CFG_DST_MASK = 2'd2,
    CFG_UNUSED   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/mirror_cfg_regs.sv
module mirror_cfg_regs
  import mirror_pkg::*;
#(
  parameter int NUM_PORTS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [CFG_ADDR_W-1:0] wr_addr,
  input  logic [NUM_PORTS-1:0]  wr_data,
  output logic [NUM_PORTS-1:0]  ing_en,
  output logic [NUM_PORTS-1:0]  egr_mask,
  output logic [NUM_PORTS-1:0]  dst_mask
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ing_en   <= '0;
      egr_mask <= '0;
      dst_mask <= '0;
    end else if (wr_en) begin
      case (cfg_sel_e'(wr_addr))
        CFG_ING_EN:   ing_en   <= wr_data;
        CFG_EGR_MASK: egr_mask <= wr_data;
        CFG_DST_MASK: dst_mask <= wr_data;
        default: ;
      endcase
    end
  end

  // R10: without a write the configuration holds
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(ing_en) && $stable(egr_mask) && $stable(dst_mask)));

  // R10: the unused address changes nothing
  assert_cfg_unused_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CFG_UNUSED) |=>
      ($stable(ing_en) && $stable(egr_mask) && $stable(dst_mask)));

endmodule

// File: rtl/mirror_trigger.sv
module mirror_trigger #(
  parameter int NUM_PORTS = 8,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [PORT_W-1:0]    src_port,
  input  logic [NUM_PORTS-1:0] fwd_mask,
  input  logic                 flow_mirror,
  input  logic                 bypass,
  input  logic [NUM_PORTS-1:0] ing_en,
  input  logic [NUM_PORTS-1:0] egr_mask,
  input  logic [NUM_PORTS-1:0] dst_mask,
  output logic [NUM_PORTS-1:0] mirror_mask
);

  logic [NUM_PORTS-1:0] src_onehot;
  logic                 hit_ing;
  logic                 hit_egr;
  logic                 hit_any;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_src_dec
    assign src_onehot[p] = (src_port == PORT_W'(p));
  end

  assign hit_ing = |(src_onehot & ing_en);
  assign hit_egr = |(fwd_mask & egr_mask);
  assign hit_any = (hit_ing | hit_egr | flow_mirror) & ~bypass;

  always_comb begin
    mirror_mask = '0;
    if (hit_any) mirror_mask = dst_mask & ~src_onehot;
  end

  // R5/R6: combinational sanity next to the decision logic
  always_comb begin
    assert_bypass_comb_R5: assert (!(bypass && (mirror_mask != '0)));
    assert_src_comb_R6:    assert ((mirror_mask & src_onehot) == '0);
  end

endmodule

// File: rtl/mirror_out_stage.sv
module mirror_out_stage #(
  parameter int NUM_PORTS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [NUM_PORTS-1:0] in_fwd,
  input  logic [NUM_PORTS-1:0] in_mirror,
  output logic                 out_valid,
  output logic [NUM_PORTS-1:0] out_fwd,
  output logic [NUM_PORTS-1:0] out_mirror
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_fwd    <= '0;
      out_mirror <= '0;
    end else begin
      out_valid  <= in_valid;
      out_fwd    <= in_valid ? in_fwd    : '0;
      out_mirror <= in_valid ? in_mirror : '0;
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && out_fwd == '0 && out_mirror == '0));

  assert_fwd_pass_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_fwd == $past(in_fwd)));

endmodule

// File: rtl/mirror_select.sv
module mirror_select
  import mirror_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_wr_en,
  input  logic [CFG_ADDR_W-1:0] cfg_wr_addr,
  input  logic [NUM_PORTS-1:0]  cfg_wr_data,
  input  logic                  frm_valid,
  input  logic [PORT_W-1:0]     frm_src_port,
  input  logic [NUM_PORTS-1:0]  frm_fwd_mask,
  input  logic                  frm_flow_mirror,
  input  logic                  frm_bypass,
  output logic                  out_valid,
  output logic [NUM_PORTS-1:0]  out_fwd_mask,
  output logic [NUM_PORTS-1:0]  out_mirror_mask
);

  logic [NUM_PORTS-1:0] ing_en;
  logic [NUM_PORTS-1:0] egr_mask;
  logic [NUM_PORTS-1:0] dst_mask;
  logic [NUM_PORTS-1:0] mirror_next;

  mirror_cfg_regs #(.NUM_PORTS(NUM_PORTS)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_wr_en),
    .wr_addr  (cfg_wr_addr),
    .wr_data  (cfg_wr_data),
    .ing_en   (ing_en),
    .egr_mask (egr_mask),
    .dst_mask (dst_mask)
  );

  mirror_trigger #(.NUM_PORTS(NUM_PORTS)) u_trig (
    .src_port    (frm_src_port),
    .fwd_mask    (frm_fwd_mask),
    .flow_mirror (frm_flow_mirror),
    .bypass      (frm_bypass),
    .ing_en      (ing_en),
    .egr_mask    (egr_mask),
    .dst_mask    (dst_mask),
    .mirror_mask (mirror_next)
  );

  mirror_out_stage #(.NUM_PORTS(NUM_PORTS)) u_out (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (frm_valid),
    .in_fwd     (frm_fwd_mask),
    .in_mirror  (mirror_next),
    .out_valid  (out_valid),
    .out_fwd    (out_fwd_mask),
    .out_mirror (out_mirror_mask)
  );

  assert_bypass_R5: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_bypass) |=> (out_mirror_mask == '0));

  assert_flow_R3: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_flow_mirror && !frm_bypass) |=>
      (out_mirror_mask == ($past(dst_mask) &
                           ~(NUM_PORTS'(1) << $past(frm_src_port)))));

  assert_src_excl_R6: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> ((out_mirror_mask & (NUM_PORTS'(1) << $past(frm_src_port))) == '0));

  assert_dst_subset_R4: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> ((out_mirror_mask & ~$past(dst_mask)) == '0));

endmodule

// File: tb/test_mirror_select.sv
module test_mirror_select;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_wr_en;
  logic [1:0]    cfg_wr_addr;
  logic [NP-1:0] cfg_wr_data;
  logic          frm_valid;
  logic [PW-1:0] frm_src_port;
  logic [NP-1:0] frm_fwd_mask;
  logic          frm_flow_mirror;
  logic          frm_bypass;
  logic          out_valid;
  logic [NP-1:0] out_fwd_mask;
  logic [NP-1:0] out_mirror_mask;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  logic done = 1'b0;

  logic [NP-1:0] m_ing, m_egr, m_dst;

  always #(CLK_PERIOD/2) clk = ~clk;

  mirror_select #(.NUM_PORTS(NP)) i_mirror_select (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .frm_valid(frm_valid), .frm_src_port(frm_src_port), .frm_fwd_mask(frm_fwd_mask),
    .frm_flow_mirror(frm_flow_mirror), .frm_bypass(frm_bypass),
    .out_valid(out_valid), .out_fwd_mask(out_fwd_mask), .out_mirror_mask(out_mirror_mask)
  );

  function automatic logic [NP-1:0] exp_mirror(input logic [PW-1:0] src,
      input logic [NP-1:0] fwd, input logic flow, input logic byp);
    logic trig;
    trig = m_ing[src] | (|(fwd & m_egr)) | flow;
    if (byp || !trig) return '0;
    return m_dst & ~(NP'(1) << src);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic model_write(input logic [1:0] a, input logic [NP-1:0] d);
    case (a)
      2'd0: m_ing = d;
      2'd1: m_egr = d;
      2'd2: m_dst = d;
      default: ;
    endcase
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    model_write(a, d);
  endtask

  // Drive one frame, optionally with a write in the same cycle; check after the next edge.
  task automatic frame(input string req, input logic [PW-1:0] src, input logic [NP-1:0] fwd,
                       input logic flow, input logic byp,
                       input logic wr, input logic [1:0] wa, input logic [NP-1:0] wd);
    logic [NP-1:0] exp;
    @(negedge clk);
    frm_valid = 1'b1; frm_src_port = src; frm_fwd_mask = fwd;
    frm_flow_mirror = flow; frm_bypass = byp;
    cfg_wr_en = wr; cfg_wr_addr = wa; cfg_wr_data = wd;
    exp = exp_mirror(src, fwd, flow, byp);
    if (wr) model_write(wa, wd);
    @(posedge clk); #1;
    check("R9 valid", {31'd0, out_valid}, 32'd1);
    check("R8 fwd", {24'd0, out_fwd_mask}, {24'd0, fwd});
    check(req, {24'd0, out_mirror_mask}, {24'd0, exp});
    @(negedge clk);
    frm_valid = 1'b0; cfg_wr_en = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        summary();
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_data = '0;
    frm_valid = 1'b0; frm_src_port = '0; frm_fwd_mask = '0;
    frm_flow_mirror = 1'b0; frm_bypass = 1'b0;
    m_ing = '0; m_egr = '0; m_dst = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R11 valid", {31'd0, out_valid}, 32'd0);
    check("R11 fwd", {24'd0, out_fwd_mask}, 32'd0);
    check("R11 mirror", {24'd0, out_mirror_mask}, 32'd0);
    // R11: configuration zero -> flow-triggered frame mirrors to nothing
    frame("R11 cfg zero", 3'd2, 8'h01, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);

    cfg_write(2'd0, 8'h02);
    cfg_write(2'd1, 8'h20);
    cfg_write(2'd2, 8'hC0);
    frame("R1 ingress",  3'd1, 8'h01, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    frame("R2 egress",   3'd0, 8'h21, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    frame("R3 flow",     3'd0, 8'h01, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
    frame("R7 none",     3'd0, 8'h01, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    frame("R4 all trig", 3'd1, 8'h20, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
    frame("R5 byp ing",  3'd1, 8'h01, 1'b1, 1'b1, 1'b0, 2'd0, 8'h00);
    frame("R5 byp egr",  3'd0, 8'h20, 1'b0, 1'b1, 1'b0, 2'd0, 8'h00);
    @(posedge clk); #1;
    check("R9 idle valid", {31'd0, out_valid}, 32'd0);
    check("R9 idle mirror", {24'd0, out_mirror_mask}, 32'd0);

    cfg_write(2'd0, 8'h82);
    frame("R6 src excl", 3'd7, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    frame("R4 shared",   3'd1, 8'h08, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);

    cfg_write(2'd3, 8'hFF);
    frame("R10 unused addr", 3'd0, 8'h01, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    frame("R10 unused dst",  3'd0, 8'h01, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);

    frame("R10 same cycle", 3'd1, 8'h01, 1'b0, 1'b0, 1'b1, 2'd2, 8'h0C);
    frame("R10 next frame", 3'd1, 8'h01, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      logic wr;
      wr = ($urandom % 8) == 0;
      frame("R4 random", PW'($urandom), NP'($urandom), ($urandom % 4) == 0,
            ($urandom % 6) == 0, wr, 2'($urandom), NP'($urandom));
    end
    summary();
  end
endmodule